// File: doc/BRIEF.md
# Single-Bunch Betatron Tune Measurement Sequencer

This block runs a programmed series of tune measurements on one chosen bunch of a circulating train during each machine cycle. A table holds up to 64 measurement points. Each point sets the turn on which it starts, an excitation style, a gain and an excitation length in turns. When a point becomes current, the sequencer waits for its turn. It then replaces the damper's kick for the chosen bunch with an excitation for the programmed number of turns. After that it records the chosen bunch's position on 128 consecutive turns and streams the record out to a spectral analysis engine.

Two excitation styles exist. The noise style drives a pseudo-random kick from a 16-bit maximal-length shift register. The anti-damping style drives the damper's own kick with its sign inverted. In both styles the kick is multiplied by the point's gain, shifted right by `GAIN_SH` and saturated to the kick width. Every other bunch, and the chosen bunch outside excitation, keeps the damper's kick unchanged.

The input streams come from the turn-locked front end and cannot be held off, so they have no ready. The capture output is a valid/ready stream. A sample that is offered and not accepted stays unchanged on the output. The record advances once per turn whatever the consumer does, so a sample that arrives while the previous one is still pending is dropped, and a sticky overrun flag is raised.

Top module: `tune_seq`

## Requirements
- R1: After reset, `kick_valid`, `kick_ovr`, `cap_valid`, `cap_overrun`, `skip_seen` and `busy` are all 0. `kick_out` is 0. The noise register holds 16'hACE1.
- R2: A `cycle_start` pulse aborts any measurement in progress, clears the turn count to 0 and makes point 0 current. `busy` goes to 1 unless `num_points` is 0. A `num_points` above 64 counts as 64.
- R3: Turns are counted by `turn_mark` pulses. A point with turn T starts excitation at the marker that brings the count to T, and excites for `dur` turns. Overrides are registered one cycle after the slot: `kick_ovr`=1 only for the slot whose `pos_bunch` equals `sel_bunch`. In every other cycle, `kick_out` is the previous cycle's `kick_in`.
- R4: With mode bit 1 (noise), the override value is sat((signed N × gain) >>> GAIN_SH). N is the shift register before the step. The register steps once per noise override, shifting left and inserting the XOR of bits 15, 13, 12 and 10. The seed is 16'hACE1.
- R5: With mode bit 0 (anti-damping), the override value is sat((−kick_in × gain) >>> GAIN_SH). Saturation clamps to [−32768, 32767].
- R6: Capture starts on the turn after excitation ends and takes the chosen bunch's samples on 128 turns. Each sample is presented with `cap_point` equal to the point index. `cap_last`=1 only on the 128th sample.
- R7: While `cap_valid`=1 and `cap_ready`=0, the `cap_data`, `cap_last` and `cap_point` outputs hold. A sample that arrives while the previous one is pending is dropped and sets `cap_overrun`. The flag is cleared only by `cycle_start`.
- R8: If a point's turn is not above the turn count when the point becomes current, the point is skipped and `skip_seen` is set until the next `cycle_start`.
- R9: After the last point's capture, the sequencer goes idle: `busy`=0 and no further overrides occur.
- R10: A point with `dur`=0 does no excitation and starts capture on turn T itself.
- R11: A table write (`tbl_we`) stores turn, mode, gain and dur at `tbl_addr`. `sel_bunch` chooses the bunch that is excited and recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Start of machine cycle pulse |
| turn_mark | input | 1 | Turn marker pulse; never coincides with pos_valid or cycle_start |
| pos_valid | input | 1 | Bunch slot valid |
| pos_bunch | input | 7 | Bunch index of the slot |
| pos_data | input | 16 | Bunch position sample |
| kick_in | input | 16 | Damper kick for the slot (signed) |
| sel_bunch | input | 7 | Bunch under measurement |
| num_points | input | 7 | Number of points per cycle |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table entry index |
| tbl_turn | input | 16 | Start turn of the entry |
| tbl_mode | input | 1 | 1 noise, 0 anti-damping |
| tbl_gain | input | 8 | Unsigned gain |
| tbl_dur | input | 8 | Excitation length in turns |
| kick_valid | output | 1 | Kick slot valid |
| kick_ovr | output | 1 | Kick replaced by excitation |
| kick_out | output | 16 | Kick toward the amplifier (signed) |
| cap_valid | output | 1 | Capture sample valid |
| cap_ready | input | 1 | Capture consumer ready |
| cap_data | output | 16 | Captured position |
| cap_last | output | 1 | 128th sample of a record |
| cap_point | output | 6 | Point index of the record |
| cap_overrun | output | 1 | Sticky sample-dropped flag |
| skip_seen | output | 1 | Sticky skipped-point flag |
| busy | output | 1 | Sequencer not idle |

## Verification
On every cycle, the assertions check the following:
- An override only ever lands in the chosen bunch's slot during excitation.
- Every other slot carries the damper's kick unchanged.
- The capture output holds under back-pressure.
- A point whose turn has passed raises the skip flag.
- No override follows an idle state.
- The noise register never locks at zero.

Only the bench's scenarios, compared against a behavioural model on every clock, can show the rest:
- The exact noise values and the saturation.
- The 128-sample record length and the last flag.
- The turn on which each point starts.
- The zero-length excitation case.
- Overrun under a stalled consumer.
- The abort on a mid-capture cycle start.

// File: rtl/tune_seq_pkg.sv
package tune_seq_pkg;
  parameter int TURN_W = 16;
  parameter int GAIN_W = 8;
  parameter int DUR_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_EXC, ST_CAP, ST_NEXT
  } seq_state_t;

  typedef struct packed {
    logic [TURN_W-1:0] turn;
    logic              noise;
    logic [GAIN_W-1:0] gain;
    logic [DUR_W-1:0]  dur;
  } meas_entry_t;
endpackage

// File: rtl/tune_noise_lfsr.sv
module tune_noise_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  logic fb;
  assign fb = value[15] ^ value[13] ^ value[12] ^ value[10];

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= SEED;
    else if (step) value <= {value[W-2:0], fb};
  end

  a_r4_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    value != '0);
endmodule

// File: rtl/tune_kick_path.sv
module tune_kick_path #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 8,
  parameter int GAIN_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] kick_in,
  input  logic              excite,
  input  logic              use_noise,
  input  logic [DATA_W-1:0] noise,
  input  logic [GAIN_W-1:0] gain,
  output logic              k_valid,
  output logic              k_ovr,
  output logic [DATA_W-1:0] k_out
);
  localparam int PW = DATA_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] SMAX = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = ~SMAX;

  logic signed [DATA_W:0] src;
  logic signed [PW-1:0]   prod, scaled;
  logic [DATA_W-1:0]      sat_v;

  always_comb begin
    src = use_noise ? $signed({noise[DATA_W-1], noise})
                    : -$signed({kick_in[DATA_W-1], kick_in});
    prod   = PW'(src) * PW'($signed({1'b0, gain}));
    scaled = prod >>> GAIN_SH;
    if (scaled > SMAX)      sat_v = SMAX[DATA_W-1:0];
    else if (scaled < SMIN) sat_v = SMIN[DATA_W-1:0];
    else                    sat_v = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_valid <= 1'b0;
      k_ovr   <= 1'b0;
      k_out   <= '0;
    end else begin
      k_valid <= in_valid;
      k_ovr   <= excite;
      k_out   <= excite ? sat_v : kick_in;
    end
  end
endmodule

// File: rtl/tune_cap_stage.sv
module tune_cap_stage #(
  parameter int DATA_W = 16,
  parameter int PT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [DATA_W-1:0] d,
  input  logic              d_last,
  input  logic [PT_W-1:0]   d_pt,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] q,
  output logic              q_last,
  output logic [PT_W-1:0]   q_pt,
  output logic              overrun
);
  logic blocked;
  assign blocked = valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      q       <= '0;
      q_last  <= 1'b0;
      q_pt    <= '0;
      overrun <= 1'b0;
    end else begin
      if (clr)                  overrun <= 1'b0;
      else if (take && blocked) overrun <= 1'b1;
      if (take) begin
        if (!blocked) begin
          valid  <= 1'b1;
          q      <= d;
          q_last <= d_last;
          q_pt   <= d_pt;
        end
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(q) && $stable(q_last) && $stable(q_pt)));
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_seq_pkg::*;
#(
  parameter int NUM_BUNCH = 84,
  parameter int MAX_POINTS = 64,
  parameter int CAP_TURNS = 128,
  parameter int DATA_W = 16,
  parameter int GAIN_SH = 4,
  localparam int BIDX_W = $clog2(NUM_BUNCH),
  localparam int PT_W = $clog2(MAX_POINTS),
  localparam int CNT_W = $clog2(CAP_TURNS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              turn_mark,
  input  logic              pos_valid,
  input  logic [BIDX_W-1:0] pos_bunch,
  input  logic [DATA_W-1:0] pos_data,
  input  logic [DATA_W-1:0] kick_in,
  input  logic [BIDX_W-1:0] sel_bunch,
  input  logic [PT_W:0]     num_points,
  input  logic              tbl_we,
  input  logic [PT_W-1:0]   tbl_addr,
  input  logic [TURN_W-1:0] tbl_turn,
  input  logic              tbl_mode,
  input  logic [GAIN_W-1:0] tbl_gain,
  input  logic [DUR_W-1:0]  tbl_dur,
  output logic              kick_valid,
  output logic              kick_ovr,
  output logic [DATA_W-1:0] kick_out,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_last,
  output logic [PT_W-1:0]   cap_point,
  output logic              cap_overrun,
  output logic              skip_seen,
  output logic              busy
);
  seq_state_t        st;
  logic [PT_W-1:0]   idx;
  logic [TURN_W-1:0] turn_cnt;
  logic [DUR_W-1:0]  exc_left;
  logic [CNT_W-1:0]  cap_cnt;
  meas_entry_t       tbl [MAX_POINTS];
  meas_entry_t       ent;
  logic [PT_W:0]     eff;
  logic              hit, excite, take, last_pt, rec_end;
  logic [DATA_W-1:0] noise;

  always_ff @(posedge clk) begin
    if (tbl_we) tbl[tbl_addr] <= '{turn: tbl_turn, noise: tbl_mode, gain: tbl_gain, dur: tbl_dur};
  end

  assign ent     = tbl[idx];
  assign eff     = (num_points > (PT_W+1)'(MAX_POINTS)) ? (PT_W+1)'(MAX_POINTS) : num_points;
  assign last_pt = ({1'b0, idx} == eff - 1'b1);
  assign hit     = pos_valid && (pos_bunch == sel_bunch);
  assign excite  = (st == ST_EXC) && hit;
  assign take    = (st == ST_CAP) && hit;
  assign rec_end = (cap_cnt == CNT_W'(CAP_TURNS - 1));
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      turn_cnt  <= '0;
      exc_left  <= '0;
      cap_cnt   <= '0;
      skip_seen <= 1'b0;
    end else if (cycle_start) begin
      turn_cnt  <= '0;
      idx       <= '0;
      cap_cnt   <= '0;
      skip_seen <= 1'b0;
      st        <= (eff != '0) ? ST_WAIT : ST_IDLE;
    end else begin
      if (turn_mark) turn_cnt <= turn_cnt + 1'b1;
      unique case (st)
        ST_IDLE: ;
        ST_WAIT: begin
          if (ent.turn <= turn_cnt) begin
            skip_seen <= 1'b1;
            st        <= ST_NEXT;
          end else if (turn_mark && (turn_cnt + 1'b1 == ent.turn)) begin
            cap_cnt  <= '0;
            exc_left <= ent.dur;
            st       <= (ent.dur == '0) ? ST_CAP : ST_EXC;
          end
        end
        ST_EXC: begin
          if (turn_mark) begin
            if (exc_left == DUR_W'(1)) st <= ST_CAP;
            exc_left <= exc_left - 1'b1;
          end
        end
        ST_CAP: begin
          if (hit) begin
            cap_cnt <= cap_cnt + 1'b1;
            if (rec_end) st <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (last_pt) st <= ST_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  tune_noise_lfsr #(.W(DATA_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(excite && ent.noise), .value(noise)
  );

  tune_kick_path #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_SH(GAIN_SH)) u_kick (
    .clk(clk), .rst_n(rst_n), .in_valid(pos_valid), .kick_in(kick_in),
    .excite(excite), .use_noise(ent.noise), .noise(noise), .gain(ent.gain),
    .k_valid(kick_valid), .k_ovr(kick_ovr), .k_out(kick_out)
  );

  tune_cap_stage #(.DATA_W(DATA_W), .PT_W(PT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(cycle_start), .take(take),
    .d(pos_data), .d_last(rec_end), .d_pt(idx), .ready(cap_ready),
    .valid(cap_valid), .q(cap_data), .q_last(cap_last), .q_pt(cap_point),
    .overrun(cap_overrun)
  );

  a_r3_ovr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ovr |-> ($past(st) == ST_EXC && $past(pos_valid) && $past(pos_bunch) == $past(sel_bunch)));
  a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_valid && !kick_ovr) |-> (kick_out == $past(kick_in)));
  a_r8_skip_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !cycle_start && ent.turn <= turn_cnt) |=> skip_seen);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !cycle_start) |=> !kick_ovr);
endmodule

// File: tb/tb_tune_seq.sv
module tb_tune_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 84;

  logic clk = 0, rst_n = 0;
  logic cycle_start = 0, turn_mark = 0, pos_valid = 0;
  logic [6:0] pos_bunch = 0, sel_bunch = 0, num_points = 0;
  logic [15:0] pos_data = 0, kick_in = 0;
  logic tbl_we = 0, tbl_mode = 0;
  logic [5:0] tbl_addr = 0;
  logic [15:0] tbl_turn = 0;
  logic [7:0] tbl_gain = 0, tbl_dur = 0;
  logic kick_valid, kick_ovr, cap_valid, cap_last, cap_overrun, skip_seen, busy;
  logic cap_ready = 1;
  logic [15:0] kick_out, cap_data;
  logic [5:0] cap_point;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_seq dut (.*);

  int checks = 0, fails = 0, cyc = 0, tcnt = 0, rdy_mode = 0;
  int ovr_cnt = 0, p3_seen = 0;
  // table mirror
  int t_turn[64], t_noise[64], t_gain[64], t_dur[64];
  // model state: 0 idle 1 wait 2 exc 3 cap 4 next
  int mst, midx, mturn, mexc, mcnt, mskip, kv, ko, kout, kreq, mv, md, ml, mp, mov;
  logic [15:0] mlfsr;

  function automatic int sat16(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; midx = 0; mturn = 0; mexc = 0; mcnt = 0; mskip = 0;
      kv = 0; ko = 0; kout = 0; kreq = 3; mv = 0; md = 0; ml = 0; mp = 0; mov = 0;
      mlfsr = 16'hACE1;
    end else begin
      bit hit, take, blk;
      int eff, t0, v;
      eff = (num_points > 64) ? 64 : int'(num_points);
      hit = pos_valid && (pos_bunch == sel_bunch);
      kv = pos_valid;
      ko = (mst == 2) && hit;
      if (ko) begin
        if (t_noise[midx] != 0) begin
          v = int'($signed(mlfsr));
          mlfsr = {mlfsr[14:0], mlfsr[15]^mlfsr[13]^mlfsr[12]^mlfsr[10]};
          kreq = 4;
        end else begin
          v = -int'($signed(kick_in));
          kreq = 5;
        end
        kout = sat16((v * t_gain[midx]) >>> 4);
      end else begin
        kout = int'($signed(kick_in));
        kreq = 3;
      end
      take = (mst == 3) && hit;
      blk = mv && !cap_ready;
      if (cycle_start) mov = 0;
      else if (take && blk) mov = 1;
      if (take) begin
        if (!blk) begin mv = 1; md = int'(pos_data); ml = (mcnt == 127); mp = midx; end
      end else if (cap_ready) mv = 0;
      t0 = mturn;
      if (cycle_start) begin
        mturn = 0; midx = 0; mcnt = 0; mskip = 0; mst = (eff > 0) ? 1 : 0;
      end else begin
        if (turn_mark) mturn++;
        case (mst)
          1: if (t_turn[midx] <= t0) begin mskip = 1; mst = 4; end
             else if (turn_mark && t0 + 1 == t_turn[midx]) begin
               mcnt = 0; mexc = t_dur[midx]; mst = (mexc == 0) ? 3 : 2;
             end
          2: if (turn_mark) begin if (mexc == 1) mst = 3; mexc--; end
          3: if (hit) begin mcnt++; if (mcnt == 128) mst = 4; end
          4: if (midx == eff - 1) mst = 0; else begin midx++; mst = 1; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string kr;
      kr = (kreq == 4) ? "R4" : (kreq == 5) ? "R5" : "R3";
      chk(kick_valid == kv[0], "R3", kick_valid, kv, "kick_valid");
      chk(kick_ovr == ko[0], "R3", kick_ovr, ko, "kick_ovr");
      chk(int'($signed(kick_out)) == kout, kr, int'($signed(kick_out)), kout, "kick_out");
      chk(cap_valid == mv[0], "R6", cap_valid, mv, "cap_valid");
      if (mv != 0) begin
        chk(int'(cap_data) == md, "R6", cap_data, md, "cap_data");
        chk(cap_last == ml[0], "R6", cap_last, ml, "cap_last");
        chk(int'(cap_point) == mp, "R6", cap_point, mp, "cap_point");
      end
      chk(cap_overrun == mov[0], "R7", cap_overrun, mov, "cap_overrun");
      chk(skip_seen == mskip[0], "R8", skip_seen, mskip, "skip_seen");
      chk(busy == (mst != 0), "R9", busy, mst != 0, "busy");
      if (kick_ovr) ovr_cnt++;
      if (cap_valid && cap_point == 3) p3_seen++;
    end
    case (rdy_mode)
      1: cap_ready <= ((cyc / 300) % 2) == 0;
      default: cap_ready <= 1'b1;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual %0d expected <= 200000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drive_idle();
    @(negedge clk);
    cycle_start = 0; turn_mark = 0; pos_valid = 0; tbl_we = 0;
  endtask

  task automatic wr(int a, int t, int n, int g, int d);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 6'(a); tbl_turn = 16'(t); tbl_mode = n[0];
    tbl_gain = 8'(g); tbl_dur = 8'(d);
    t_turn[a] = t; t_noise[a] = n; t_gain[a] = g; t_dur[a] = d;
    drive_idle();
  endtask

  task automatic start_cycle();
    @(negedge clk);
    cycle_start = 1; turn_mark = 0; pos_valid = 0;
    drive_idle();
    tcnt = 0;
  endtask

  task automatic run_turns(int n);
    for (int k = 0; k < n; k++) begin
      tcnt++;
      @(negedge clk);
      turn_mark = 1; pos_valid = 0;
      for (int b = 0; b < NB; b++) begin
        @(negedge clk);
        turn_mark = 0; pos_valid = 1; pos_bunch = 7'(b);
        pos_data = 16'(tcnt * 31 + b * 7);
        kick_in = 16'((tcnt * 4099) ^ (b * 77));
      end
    end
    drive_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!kick_valid && !kick_ovr && kick_out == 0 && !cap_valid && !cap_overrun && !skip_seen && !busy,
        "R1", busy, 0, "reset outputs");
    // R11 cycle 1 table: noise, skipped, anti-damping, zero-length
    sel_bunch = 5; num_points = 4;
    wr(0, 2, 1, 40, 3);
    wr(1, 3, 1, 10, 1);
    wr(2, 135, 0, 200, 2);
    wr(3, 270, 1, 255, 0);
    rdy_mode = 1;
    start_cycle();
    @(negedge clk);
    chk(busy, "R2", busy, 1, "busy after cycle start");
    ovr_cnt = 0;
    run_turns(400);
    repeat (3) @(negedge clk);
    chk(ovr_cnt == 5, "R3", ovr_cnt, 5, "override count cycle 1");
    chk(skip_seen, "R8", skip_seen, 1, "skip flag");
    chk(cap_overrun, "R7", cap_overrun, 1, "overrun under stall");
    chk(p3_seen > 0, "R10", p3_seen, 1, "zero-length point captured");
    chk(!busy, "R9", busy, 0, "idle after last point");
    // cycle 2: other bunch, aborted mid capture
    rdy_mode = 0;
    sel_bunch = 83; num_points = 2;
    wr(0, 1, 1, 64, 2);
    wr(1, 20, 0, 100, 1);
    start_cycle();
    chk(!cap_overrun, "R7", cap_overrun, 0, "overrun cleared");
    ovr_cnt = 0;
    run_turns(60);
    chk(ovr_cnt == 2, "R11", ovr_cnt, 2, "overrides on bunch 83");
    num_points = 0;
    start_cycle();
    ovr_cnt = 0;
    run_turns(3);
    chk(!busy, "R2", busy, 0, "zero points stays idle");
    chk(ovr_cnt == 0, "R9", ovr_cnt, 0, "no override after abort");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule